// File: doc/BRIEF.md
# PWM Event Output Conditioner

The block takes the event signals produced by eight PWM generators and drives one of them to an output pin and an interrupt line. A 16-bit control word picks the source in two steps: first a generator, then one of that generator's event signals. The chosen signal then passes through a fixed chain of optional stages. It can be stretched, so that a short high-speed event lasts long enough for slow or off-chip logic to see it. It can be synchronized into the PWM clock domain. It can be inverted, and it is gated by an output enable.

The interrupt request is a one-cycle pulse on each rising edge of the conditioned event. It is taken before the polarity stage and does not depend on the output enable, so software can be told about an event even when the pin is not driven. When a stage is turned off, the signal bypasses it without any delay.

Top module: `pwm_evt_cond`

## Requirements
- R1: The source is bit `gen_evt[g*16 + s]`, where g is `ctrl[2:0]` (generator) and s is `ctrl[7:4]` (signal). Signal index 0 carries a generator's default trigger output.
- R2: When `ctrl[13]` and `ctrl[12]` are both clear, the selected signal reaches `evt_pin` in the same cycle, with no register on the path.
- R3: When `ctrl[13]` is set, the stretch stage goes high in the cycle the selected signal is high and stays high for 8 more cycles after the last high cycle. A new high cycle during that window restarts the count.
- R4: When `ctrl[12]` is set, the output of the stretch stage reaches the pin through two flip-flops, which delays it by two cycles.
- R5: The stages are applied in this order: select, stretch, synchronize, invert, gate. With both stretch and sync on, the stretched pulse appears two cycles later at full length.
- R6: When `ctrl[14]` is set, the conditioned signal is inverted before it reaches `evt_pin`.
- R7: `evt_pin_oe` follows `ctrl[15]`. While it is low, `evt_pin` is held low.
- R8: `evt_irq` is high for exactly one cycle. That cycle follows the clock edge that first samples the synchronized-or-bypassed signal high, taken before inversion. `evt_irq` ignores `ctrl[14]` and `ctrl[15]`.
- R9: While `rst_n` is low, `evt_pin`, `evt_pin_oe` and `evt_irq` are all low and every internal state is cleared, whatever `ctrl` holds.
- R10: Control bits 3 and 11:8 are reserved and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_evt | input | 128 | Event signals; generator g, signal s at bit g*16+s |
| ctrl | input | 16 | Control word (source select, stretch, sync, invert, enable) |
| evt_pin | output | 1 | Conditioned event pin |
| evt_pin_oe | output | 1 | Output enable for the pin |
| evt_irq | output | 1 | One-cycle interrupt request |

## Verification
The stretch-length property assumes that the control word does not change during the whole high run it judges, including the low sample before the run. For that reason the checker only judges runs that start and end under an unchanged control word. The interrupt properties assume that the pin state in the previous cycle was observed under the same enable. The stimulus meets these assumptions by changing `ctrl` only between stimulus phases and by driving events as whole-cycle levels on the falling edge, never mid-cycle.

// File: rtl/pwm_evt_cond.sv
module pwm_evt_cond #(
  parameter int NUM_GEN     = 8,
  parameter int SIG_PER_GEN = 16,
  parameter int STRETCH_CYC = 8,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_GEN*SIG_PER_GEN-1:0] gen_evt,
  input  logic [15:0]                    ctrl,
  output logic                           evt_pin,
  output logic                           evt_pin_oe,
  output logic                           evt_irq
);

  localparam int GSEL_W   = $clog2(NUM_GEN);
  localparam int SSEL_W   = $clog2(SIG_PER_GEN);
  localparam int CNT_W    = $clog2(STRETCH_CYC + 1);
  localparam int GSEL_LSB = 0;
  localparam int SSEL_LSB = 4;
  localparam int SYNC_BIT = 12;
  localparam int STR_BIT  = 13;
  localparam int INV_BIT  = 14;
  localparam int OE_BIT   = 15;

  logic [GSEL_W-1:0] gsel;
  logic [SSEL_W-1:0] ssel;
  logic              sync_en, str_en, inv_en, out_en;
  logic              unused_rsvd;

  assign gsel    = ctrl[GSEL_LSB +: GSEL_W];
  assign ssel    = ctrl[SSEL_LSB +: SSEL_W];
  assign sync_en = ctrl[SYNC_BIT];
  assign str_en  = ctrl[STR_BIT];
  assign inv_en  = ctrl[INV_BIT];
  assign out_en  = ctrl[OE_BIT];
  assign unused_rsvd = ^{ctrl[11:8], ctrl[3]};

  logic [NUM_GEN-1:0] gen_pick;
  logic               sel_evt;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen_mux
    logic [SIG_PER_GEN-1:0] slice;
    assign slice       = gen_evt[g*SIG_PER_GEN +: SIG_PER_GEN];
    assign gen_pick[g] = slice[ssel];
  end

  assign sel_evt = gen_pick[gsel];

  logic [CNT_W-1:0] hold_cnt;
  logic             stretched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_cnt <= '0;
    else if (!str_en)          hold_cnt <= '0;
    else if (sel_evt)          hold_cnt <= CNT_W'(STRETCH_CYC);
    else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
  end

  assign stretched = sel_evt | (str_en & (hold_cnt != '0));

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_DEPTH-2:0], stretched};
  end

  assign synced = sync_en ? sync_q[SYNC_DEPTH-1] : stretched;

  logic prev_synced, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_synced <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      prev_synced <= synced;
      irq_q       <= synced & ~prev_synced;
    end
  end

  assign evt_irq    = irq_q;
  assign evt_pin_oe = out_en & rst_n;
  assign evt_pin    = evt_pin_oe & (synced ^ inv_en);

endmodule

// File: rtl/pwm_evt_cond_chk.sv
module pwm_evt_cond_chk #(
  parameter int STRETCH_CYC = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctrl,
  input logic        evt_pin,
  input logic        evt_pin_oe,
  input logic        evt_irq
);

  logic [15:0] ctrl_q;
  logic        prev_pin;
  logic [7:0]  run_len, cfg_age;
  logic        str_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      prev_pin <= 1'b0;
      run_len  <= '0;
      cfg_age  <= '0;
    end else begin
      ctrl_q   <= ctrl;
      prev_pin <= evt_pin;
      run_len  <= evt_pin ? ((run_len == 8'hFF) ? run_len : run_len + 8'd1) : 8'd0;
      cfg_age  <= (ctrl != ctrl_q) ? 8'd0 :
                  ((cfg_age == 8'hFF) ? cfg_age : cfg_age + 8'd1);
    end
  end

  assign str_cfg = (ctrl[15:12] == 4'b1010);

  a_r7_pin_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_pin_oe |-> !evt_pin);

  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq |=> !evt_irq);

  a_r8_irq_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_irq && $past(evt_pin_oe)) |-> $past(evt_pin ^ ctrl[14]));

  a_r3_stretch_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    (str_cfg && ctrl == ctrl_q && cfg_age > run_len && prev_pin && !evt_pin)
      |-> (int'(run_len) >= STRETCH_CYC + 1));

endmodule

bind pwm_evt_cond pwm_evt_cond_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl       (ctrl),
  .evt_pin    (evt_pin),
  .evt_pin_oe (evt_pin_oe),
  .evt_irq    (evt_irq)
);

// File: tb/sim_pwm_evt_cond.sv
`timescale 1ns/1ps
module sim_pwm_evt_cond;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] gen_evt = '0;
  logic [15:0]  ctrl = 16'hF000;
  logic         evt_pin, evt_pin_oe, evt_irq;

  always #2.5 clk = ~clk;

  pwm_evt_cond u0 (
    .clk(clk), .rst_n(rst_n), .gen_evt(gen_evt), .ctrl(ctrl),
    .evt_pin(evt_pin), .evt_pin_oe(evt_pin_oe), .evt_irq(evt_irq)
  );

  typedef struct {
    logic  pin;
    logic  oe;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  int m_cnt = 0;
  bit m_s1 = 0, m_s2 = 0, m_prev = 0, m_irq = 0;

  task automatic drive(input logic [127:0] ev, input logic [15:0] c,
                       input logic r, input string tag);
    exp_t e;
    bit   sel, sten, syen, inv, oe, str, syn;
    int   idx;
    @(negedge clk);
    gen_evt = ev;
    ctrl    = c;
    rst_n   = r;
    if (!r) begin
      m_cnt = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_irq = 0;
    end
    idx  = int'(c[2:0]) * 16 + int'(c[7:4]);
    sel  = ev[idx];
    syen = c[12]; sten = c[13]; inv = c[14]; oe = c[15];
    str  = sten ? (sel || m_cnt != 0) : sel;
    syn  = syen ? m_s2 : str;
    e.oe  = oe && r;
    e.pin = e.oe && (syn ^ inv);
    e.irq = m_irq;
    e.tag = tag;
    q.push_back(e);
    if (r) begin
      m_cnt  = !sten ? 0 : (sel ? 8 : (m_cnt != 0 ? m_cnt - 1 : 0));
      m_s2   = m_s1;
      m_s1   = str;
      m_irq  = syn && !m_prev;
      m_prev = syn;
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_chk++;
      if (evt_pin !== e.pin || evt_pin_oe !== e.oe || evt_irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s: pin/oe/irq actual %b%b%b expected %b%b%b at %0t",
                 e.tag, evt_pin, evt_pin_oe, evt_irq, e.pin, e.oe, e.irq, $time);
      end
    end
  end

  function automatic logic [127:0] one(input int g, input int s);
    logic [127:0] v = '0;
    v[g*16 + s] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] cw(input logic [3:0] mode, input int g, input int s);
    return {mode, 4'h0, 4'(s), 1'b0, 3'(g)};
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) drive({128{1'b1}}, 16'hFFFF, 1'b0, "R9");
    drive('0, 16'h0000, 1'b0, "R9");
    drive('0, 16'h0000, 1'b1, "R9");

    // R1: generator/signal selection, one-hot and inverted one-hot patterns
    for (int g = 0; g < 8; g++) begin
      int s = (g * 5 + 3) % 16;
      drive(one(g, s),  cw(4'h8, g, s), 1'b1, "R1");
      drive(~one(g, s), cw(4'h8, g, s), 1'b1, "R1");
      drive('0,         cw(4'h8, g, s), 1'b1, "R1");
    end
    drive(one(2, 0),  cw(4'h8, 2, 0), 1'b1, "R1");
    drive(one(2, 1),  cw(4'h8, 2, 0), 1'b1, "R1");
    drive(one(3, 0),  cw(4'h8, 2, 0), 1'b1, "R1");

    // R2: same-cycle pass-through
    for (int i = 0; i < 6; i++)
      drive((i == 1 || i == 3 || i == 4) ? one(3, 7) : '0, cw(4'h8, 3, 7), 1'b1, "R2");

    // R10: reserved bits ignored
    for (int i = 0; i < 4; i++)
      drive(i[0] ? one(3, 7) : '0, cw(4'h8, 3, 7) | 16'h0F08, 1'b1, "R10");

    // R3: stretch, single pulse then retrigger
    drive(one(5, 9), cw(4'hA, 5, 9), 1'b1, "R3");
    for (int i = 0; i < 11; i++) drive('0, cw(4'hA, 5, 9), 1'b1, "R3");
    drive(one(5, 9), cw(4'hA, 5, 9), 1'b1, "R3");
    for (int i = 0; i < 4; i++) drive('0, cw(4'hA, 5, 9), 1'b1, "R3");
    drive(one(5, 9), cw(4'hA, 5, 9), 1'b1, "R3");
    for (int i = 0; i < 12; i++) drive('0, cw(4'hA, 5, 9), 1'b1, "R3");

    // R4: two-flop synchronizer delay
    drive(one(1, 2), cw(4'h9, 1, 2), 1'b1, "R4");
    for (int i = 0; i < 5; i++) drive('0, cw(4'h9, 1, 2), 1'b1, "R4");
    for (int i = 0; i < 3; i++) drive(one(1, 2), cw(4'h9, 1, 2), 1'b1, "R4");
    for (int i = 0; i < 5; i++) drive('0, cw(4'h9, 1, 2), 1'b1, "R4");

    // R5: stretch then sync
    drive(one(7, 15), cw(4'hB, 7, 15), 1'b1, "R5");
    for (int i = 0; i < 14; i++) drive('0, cw(4'hB, 7, 15), 1'b1, "R5");

    // R6: inversion, irq still on pre-inversion rising edge
    for (int i = 0; i < 6; i++)
      drive((i == 2 || i == 3) ? one(4, 4) : '0, cw(4'hC, 4, 4), 1'b1, "R6");

    // R7 and R8: output disabled, interrupt still raised
    for (int i = 0; i < 6; i++)
      drive((i == 1 || i == 4) ? one(6, 11) : '0, cw(4'h0, 6, 11), 1'b1, "R7");
    for (int i = 0; i < 6; i++)
      drive((i >= 1 && i <= 3) ? one(0, 6) : '0, cw(4'h4, 0, 6), 1'b1, "R8");

    // R9: reset in the middle of a stretch
    drive(one(5, 9), cw(4'hA, 5, 9), 1'b1, "R9");
    drive('0, cw(4'hA, 5, 9), 1'b0, "R9");
    for (int i = 0; i < 3; i++) drive('0, cw(4'hA, 5, 9), 1'b1, "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule